// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block takes a single serial receive line and turns each start-bit framed character on it into a parallel byte for a host. It runs on the system clock. The receive timing comes from a one-cycle clock-enable pulse, `os_tick_i`, which is 1, 16 or 64 times the bit rate, as a run-time mode field selects. The line is synchronised inside the block. In the oversampled modes, a start bit must still be low at its centre before the character is accepted. Every later bit is then taken at its own centre.

The character format comes from the low six bits of the same packed mode byte that the companion transmitter uses: the oversampling factor, the character length of 5 to 8 bits, whether a parity bit is present, and its sense. A completed character raises a ready flag and is held for the host. The host takes it with a one-cycle read strobe. The block keeps three sticky error bits: parity, overrun and framing. They stay set until the host pulses the error-reset command.

Top module: `async_rx_unit`

## Requirements
- R1: After reset, `rx_ready_o` is 0, `rx_data_o` is 0 and `rx_status_o` is 3'b000.
- R2: `mode_i[1:0]` selects the number of `os_tick_i` pulses per bit: 2'b01 gives 1, 2'b10 gives 16 and 2'b11 gives 64. The value 2'b00 is treated as 1.
- R3: `mode_i[3:2]` selects the character length: 2'b00 is 5 bits, 2'b01 is 6, 2'b10 is 7 and 2'b11 is 8. Data bits arrive LSB first and are placed from `rx_data_o[0]` upward. Bits above the character length read as 0.
- R4: `mode_i[4]`=1 means a parity bit follows the data. `mode_i[5]`=1 selects even parity and 0 selects odd. A mismatch sets `rx_status_o[0]`.
- R5: In the 16x and 64x modes, a low level seen on the line while idle is accepted as a start bit only if it is still low factor/2 ticks later. Otherwise it is discarded and no character is produced.
- R6: A first stop bit sampled low sets `rx_status_o[2]`, and the character is still delivered. A new start bit is not accepted until the line has been seen high.
- R7: `rx_ready_o` and `rx_data_o` update two clock cycles after the tick that samples the stop bit. A read strobe `rd_stb_i` clears `rx_ready_o` on the next clock edge.
- R8: If a character completes while `rx_ready_o` is still 1 and no read happens in that cycle, the held data is replaced and `rx_status_o[1]` (overrun) is set.
- R9: The error bits are sticky. A pulse on `err_rst_i` clears them on the next edge, and `rx_ready_o` is not affected. Errors detected in the same cycle as the pulse are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| os_tick_i | input | 1 | Receive clock enable, one pulse per oversampling period |
| rxd_i | input | 1 | Serial receive line, idle high |
| mode_i | input | 6 | Low bits of the mode byte: factor [1:0], length [3:2], parity enable [4], even parity [5] |
| rd_stb_i | input | 1 | Host read strobe, one cycle |
| err_rst_i | input | 1 | Error-reset command, one cycle |
| rx_data_o | output | 8 | Held received character, zero-extended |
| rx_ready_o | output | 1 | A character is waiting for the host |
| rx_status_o | output | 3 | Sticky errors: [2] framing, [1] overrun, [0] parity |

## Verification
A line level takes two clock cycles to reach the sampler. A character's data, ready flag and error bits appear two cycles after the tick that samples its stop bit. A read strobe or error reset takes effect at the next clock edge. The bench changes the line only half a cycle after a tick, so every level has settled through the synchroniser before the next tick. It checks a character only after two further idle bit times, which is well past the point where the result is due. It then drives each strobe for one cycle and samples at the falling edge that follows the single edge where the strobe acts.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_PAR   = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_e;

  // Sticky error word, packed so that frame lands in bit 2 and parity in bit 0
  typedef struct packed {
    logic frame;
    logic ovr;
    logic par;
  } rx_err_t;

  // Oversampling factor codes in mode bits [1:0]
  localparam logic [1:0] OS_X1_ALT = 2'b00;
  localparam logic [1:0] OS_X1     = 2'b01;
  localparam logic [1:0] OS_X16    = 2'b10;
  localparam logic [1:0] OS_X64    = 2'b11;

endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/async_rx_sampler.sv
module async_rx_sampler
  import async_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              x1_i,
  input  logic [CNT_W-1:0]  reload_i,
  input  logic [CNT_W-1:0]  half_m1_i,
  input  logic [BIT_W-1:0]  last_idx_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_err_o,
  output logic              frm_err_o
);

  rx_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BIT_W-1:0]   idx_q, idx_d;
  logic [DATA_W-1:0]  shr_q, shr_d;
  logic               acc_q, acc_d;
  logic               armed_q, armed_d;
  logic               done_q, done_d;
  logic               perr_q, perr_d;
  logic               ferr_q, ferr_d;
  logic               at_point;

  assign at_point = tick_i && (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shr_d   = shr_q;
    acc_d   = acc_q;
    armed_d = armed_q;
    done_d  = 1'b0;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    if (tick_i) begin
      unique case (state_q)
        RX_IDLE: begin
          if (rxd_i) begin
            armed_d = 1'b1;
          end else if (armed_q) begin
            shr_d  = '0;
            idx_d  = '0;
            acc_d  = 1'b0;
            perr_d = 1'b0;
            if (x1_i) begin
              state_d = RX_DATA;
              cnt_d   = reload_i;
            end else begin
              state_d = RX_START;
              cnt_d   = half_m1_i;
            end
          end
        end
        RX_START: begin
          if (cnt_q == '0) begin
            if (rxd_i) begin
              state_d = RX_IDLE;
            end else begin
              state_d = RX_DATA;
              cnt_d   = reload_i;
            end
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == '0) begin
            shr_d[idx_q] = rxd_i;
            acc_d        = acc_q ^ rxd_i;
            cnt_d        = reload_i;
            if (idx_q == last_idx_i) begin
              state_d = par_en_i ? RX_PAR : RX_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        RX_PAR: begin
          if (cnt_q == '0) begin
            perr_d  = acc_q ^ rxd_i ^ ~par_even_i;
            state_d = RX_STOP;
            cnt_d   = reload_i;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == '0) begin
            done_d  = 1'b1;
            ferr_d  = ~rxd_i;
            armed_d = rxd_i;
            state_d = RX_IDLE;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shr_q   <= '0;
      acc_q   <= 1'b0;
      armed_q <= 1'b1;
      done_q  <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shr_q   <= shr_d;
      acc_q   <= acc_d;
      armed_q <= armed_d;
      done_q  <= done_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
    end
  end

  assign done_o    = done_q;
  assign data_o    = shr_q;
  assign par_err_o = perr_q;
  assign frm_err_o = ferr_q;

  // A start that is high again at its centre is dropped without a character
  assert_start_abort_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && at_point && rxd_i) |=> (state_q == RX_IDLE && !done_o));

  // The stop-bit sample produces one completion carrying its framing result
  assert_stop_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_STOP && at_point) |=> (done_o && (frm_err_o == !$past(rxd_i))));

  // Completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: rtl/async_rx_hold.sv
module async_rx_hold
  import async_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_err_i,
  input  logic              frm_err_i,
  input  logic              rd_stb_i,
  input  logic              err_rst_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] data_o,
  output rx_err_t           status_o
);

  logic              ready_q, ready_d;
  logic [DATA_W-1:0] data_q, data_d;
  rx_err_t           err_q, err_d;

  always_comb begin
    ready_d = ready_q;
    data_d  = data_q;
    err_d   = err_rst_i ? '0 : err_q;
    if (done_i) begin
      ready_d   = 1'b1;
      data_d    = data_i;
      err_d.par   = err_d.par   | par_err_i;
      err_d.frame = err_d.frame | frm_err_i;
      err_d.ovr   = err_d.ovr   | (ready_q & ~rd_stb_i);
    end else if (rd_stb_i) begin
      ready_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      data_q  <= '0;
      err_q   <= '0;
    end else begin
      ready_q <= ready_d;
      data_q  <= data_d;
      err_q   <= err_d;
    end
  end

  assign ready_o  = ready_q;
  assign data_o   = data_q;
  assign status_o = err_q;

  assert_ready_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> ready_o);

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && !done_i) |=> !ready_o);

  assert_overrun_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && ready_o && !rd_stb_i) |=> status_o.ovr);

  assert_flags_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && !err_rst_i) |=> $stable(status_o));

endmodule

// File: rtl/async_rx_unit.sv
module async_rx_unit
  import async_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_OS  = 64,
  parameter int SYNC_ST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              os_tick_i,
  input  logic              rxd_i,
  input  logic [5:0]        mode_i,
  input  logic              rd_stb_i,
  input  logic              err_rst_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_ready_o,
  output logic [2:0]        rx_status_o
);

  localparam int CNT_W = $clog2(MAX_OS);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] RLD_16  = CNT_W'(15);
  localparam logic [CNT_W-1:0] RLD_64  = CNT_W'(MAX_OS - 1);
  localparam logic [CNT_W-1:0] HALF_16 = CNT_W'(7);
  localparam logic [CNT_W-1:0] HALF_64 = CNT_W'(MAX_OS / 2 - 1);
  localparam logic [BIT_W-1:0] MIN_IDX = BIT_W'(4);

  logic              rst_n;
  logic              rxd_s;
  logic              x1;
  logic [CNT_W-1:0]  reload;
  logic [CNT_W-1:0]  half_m1;
  logic [BIT_W-1:0]  last_idx;
  logic              done;
  logic [DATA_W-1:0] smp_data;
  logic              smp_perr;
  logic              smp_ferr;
  rx_err_t           status;

  // Reset: asserted at once, released after SYNC_ST edges
  async_rx_sync #(.STAGES(SYNC_ST), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_n)
  );

  async_rx_sync #(.STAGES(SYNC_ST), .RST_VAL(1'b1)) u_rxd_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  always_comb begin
    unique case (mode_i[1:0])
      OS_X16: begin
        x1 = 1'b0; reload = RLD_16; half_m1 = HALF_16;
      end
      OS_X64: begin
        x1 = 1'b0; reload = RLD_64; half_m1 = HALF_64;
      end
      OS_X1, OS_X1_ALT: begin
        x1 = 1'b1; reload = '0; half_m1 = '0;
      end
      default: begin
        x1 = 1'b1; reload = '0; half_m1 = '0;
      end
    endcase
    last_idx = MIN_IDX + BIT_W'(mode_i[3:2]);
  end

  async_rx_sampler #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sampler (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .tick_i    (os_tick_i),
    .rxd_i     (rxd_s),
    .x1_i      (x1),
    .reload_i  (reload),
    .half_m1_i (half_m1),
    .last_idx_i(last_idx),
    .par_en_i  (mode_i[4]),
    .par_even_i(mode_i[5]),
    .done_o    (done),
    .data_o    (smp_data),
    .par_err_o (smp_perr),
    .frm_err_o (smp_ferr)
  );

  async_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .done_i   (done),
    .data_i   (smp_data),
    .par_err_i(smp_perr),
    .frm_err_i(smp_ferr),
    .rd_stb_i (rd_stb_i),
    .err_rst_i(err_rst_i),
    .ready_o  (rx_ready_o),
    .data_o   (rx_data_o),
    .status_o (status)
  );

  assign rx_status_o = status;

endmodule

// File: tb/async_rx_unit_tb_top.sv
`timescale 1ns/1ps
module async_rx_unit_tb_top;

  localparam int TDIV = 4;
  localparam int NVEC = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] tcnt = '0;
  logic       tick;
  logic       rxd = 1'b1;
  logic [5:0] mode = 6'h0E;
  logic       rd_stb = 1'b0;
  logic       err_rst = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready;
  logic [2:0] rx_status;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 1'b1;
  assign tick = (tcnt == 2'd3);

  async_rx_unit dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .os_tick_i  (tick),
    .rxd_i      (rxd),
    .mode_i     (mode),
    .rd_stb_i   (rd_stb),
    .err_rst_i  (err_rst),
    .rx_data_o  (rx_data),
    .rx_ready_o (rx_ready),
    .rx_status_o(rx_status)
  );

  // {mode6, payload8, flip parity1, stop1, expected data8, expected status3}
  localparam logic [26:0] VEC [NVEC] = '{
    {6'h0E, 8'hA5, 1'b0, 1'b1, 8'hA5, 3'b000},
    {6'h01, 8'hFF, 1'b0, 1'b1, 8'h1F, 3'b000},
    {6'h3B, 8'h55, 1'b0, 1'b1, 8'h55, 3'b000},
    {6'h3B, 8'h55, 1'b1, 1'b1, 8'h55, 3'b001},
    {6'h16, 8'h2A, 1'b0, 1'b1, 8'h2A, 3'b000},
    {6'h0E, 8'h3C, 1'b0, 1'b0, 8'h3C, 3'b100},
    {6'h01, 8'h00, 1'b0, 1'b0, 8'h00, 3'b100},
    {6'h3E, 8'h01, 1'b1, 1'b1, 8'h01, 3'b001},
    {6'h1A, 8'hFF, 1'b0, 1'b1, 8'h7F, 3'b000}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic int fac_of(input logic [5:0] m);
    case (m[1:0])
      2'b10:   return 16;
      2'b11:   return 64;
      default: return 1;
    endcase
  endfunction

  task automatic send_bit(input logic b, input int fac);
    rxd = b;
    repeat (fac * TDIV) @(negedge clk);
  endtask

  task automatic align();
    @(negedge clk);
    while (tcnt != 2'd0) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic flip, input logic stop);
    int   fac;
    int   len;
    logic p;
    fac = fac_of(mode);
    len = 5 + int'(mode[3:2]);
    p = 1'b0;
    align();
    send_bit(1'b0, fac);
    for (int i = 0; i < len; i++) begin
      send_bit(d[i], fac);
      p = p ^ d[i];
    end
    if (mode[4]) send_bit(p ^ ~mode[5] ^ flip, fac);
    send_bit(stop, fac);
    send_bit(1'b1, fac);
    send_bit(1'b1, fac);
  endtask

  task automatic pulse_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic pulse_err_rst();
    err_rst = 1'b1;
    @(negedge clk);
    err_rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 ready in reset", {7'd0, rx_ready}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready", {7'd0, rx_ready}, 8'h00);
    chk("R1 data", rx_data, 8'h00);
    chk("R1 status", {5'd0, rx_status}, 8'h00);

    // Table walk: R2 R3 R4 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      logic [26:0] e;
      e = VEC[v];
      mode = e[26:21];
      send_frame(e[20:13], e[12], e[11]);
      chk("R7 ready after frame", {7'd0, rx_ready}, 8'h01);
      chk("R3 data (R2 factor)", rx_data, e[10:3]);
      chk("R4/R6 status", {5'd0, rx_status}, {5'd0, e[2:0]});
      pulse_read();
      chk("R7 read clears ready", {7'd0, rx_ready}, 8'h00);
      pulse_err_rst();
      chk("R9 error reset clears", {5'd0, rx_status}, 8'h00);
    end

    // R2: code 00 behaves as one tick per bit
    mode = 6'h00;
    send_frame(8'h15, 1'b0, 1'b1);
    chk("R2 code 00 data", rx_data, 8'h15);
    pulse_read();

    // R5: short low pulse in 16x mode is not a start
    mode = 6'h0E;
    align();
    send_bit(1'b0, 3);
    send_bit(1'b1, 64);
    chk("R5 glitch gives no ready", {7'd0, rx_ready}, 8'h00);
    chk("R5 glitch gives no error", {5'd0, rx_status}, 8'h00);
    send_frame(8'hC3, 1'b0, 1'b1);
    chk("R5 next frame received", rx_data, 8'hC3);
    pulse_read();

    // R8: second character before read
    send_frame(8'h11, 1'b0, 1'b1);
    send_frame(8'h22, 1'b0, 1'b1);
    chk("R8 data replaced", rx_data, 8'h22);
    chk("R8 overrun status", {5'd0, rx_status}, 8'h02);
    pulse_err_rst();
    chk("R9 reset keeps ready", {7'd0, rx_ready}, 8'h01);
    chk("R9 overrun cleared", {5'd0, rx_status}, 8'h00);
    pulse_read();
    chk("R7 ready cleared", {7'd0, rx_ready}, 8'h00);

    // R9: parity flag survives a later good character
    mode = 6'h3E;
    send_frame(8'h01, 1'b1, 1'b1);
    pulse_read();
    send_frame(8'h03, 1'b0, 1'b1);
    chk("R9 sticky parity", {5'd0, rx_status}, 8'h01);
    chk("R9 later data", rx_data, 8'h03);
    pulse_read();
    pulse_err_rst();
    chk("R9 cleared at end", {5'd0, rx_status}, 8'h00);

    finish_run();
  end

endmodule